// File: doc/BRIEF.md
# Load Queue Issue Controller

This block keeps the per-thread queue of in-flight loads and decides, each cycle, which executing loads may present a request to the data cache. Loads are entered in program order, each tagged with a sequence number, and sit in a circular array until they commit. An older-than commit frees a run of entries from the head, and a squash discards every entry younger than a given sequence number. The array always leaves one slot unused, so the usable capacity is one less than its size.

Several execute lanes may present loads in the same cycle. Each lane names a queue slot and gives an address, an uncacheable flag and a ready-to-commit flag. An uncacheable load is passed on only when it is the oldest load in the queue and is ready to commit. Otherwise it is returned for rescheduling with a machine-check fault indication. Lanes claim cache ports in ascending lane order, up to a per-cycle limit that restarts every cycle, and lanes past the limit are sent back for rescheduling.

When the cache does not accept a request, the block keeps a record of the blocked load. Only the oldest blocked load is held. The record stays until it is explicitly cleared, and a separate input marks it as handled.

Top module: `lq_issue_ctrl`

## Requirements
- R1: After reset the queue is empty: count 0, head slot 0, not full, allocation ready, and no blocked load recorded.
- R2: An accepted allocation writes its sequence number into slot (head + count) mod DEPTH, shown on `alloc_idx`, and raises the count by one. Allocation is not accepted in a cycle where a squash is applied.
- R3: `lq_full` is high exactly when the count equals DEPTH-1, and no allocation is accepted then. Fullness is judged on the count at the start of the cycle, even when a commit frees slots in that same cycle.
- R4: A commit removes, starting from the head, every queued load whose sequence number is below `commit_seq`, and advances `head_idx` by the number removed.
- R5: A squash removes every queued load whose sequence number is above `squash_seq`.
- R6: An uncacheable load is sent to the cache only if its slot equals `head_idx` and its ready-to-commit flag is set. Otherwise the block sends no request for it and raises both reschedule and fault on that lane.
- R7: A load that passes the uncacheable rule and gets a port drives a cache request carrying its address and the sequence number stored in its slot, with no reschedule and no fault.
- R8: Ports are granted in ascending lane order, at most CACHE_PORTS per cycle, and the count starts again from zero every cycle. A lane refused only for lack of a port raises reschedule without fault.
- R9: A request that the cache does not accept sets the blocked flag in the next cycle and clears the handled flag. If several are refused in one cycle, the oldest (smallest sequence number) is recorded.
- R10: When a record is already held, a refused load replaces it only if its sequence number is smaller than the recorded one.
- R11: `blk_clear` drops the blocked flag and `blk_handled_set` sets the handled flag. A record taken in the same cycle overrides both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Enter a new load at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| alloc_idx | output | IDX_W | Slot the new load is written to |
| commit_valid | input | 1 | Apply an older-than commit |
| commit_seq | input | SEQ_W | Loads below this number are freed |
| squash_valid | input | 1 | Apply a squash |
| squash_seq | input | SEQ_W | Loads above this number are discarded |
| exec_valid | input | LANES | Per-lane execute request |
| exec_idx | input | LANES x IDX_W | Queue slot of each lane's load |
| exec_addr | input | LANES x ADDR_W | Address of each lane's load |
| exec_uncache | input | LANES | Load targets uncacheable space |
| exec_at_commit | input | LANES | Load is ready to commit |
| cache_req_valid | output | LANES | Request presented to the cache |
| cache_req_addr | output | LANES x ADDR_W | Request address |
| cache_req_seq | output | LANES x SEQ_W | Sequence number tag of the request |
| cache_ready | input | LANES | Cache accepts the lane's request |
| resched | output | LANES | Load must be reissued later |
| fault | output | LANES | Machine-check indication for a premature uncacheable load |
| blk_clear | input | 1 | Drop the blocked-load flag |
| blk_handled_set | input | 1 | Mark the blocked load as handled |
| load_blocked | output | 1 | A cache-refused load is recorded |
| blk_handled | output | 1 | The recorded load has been handled |
| blk_seq | output | SEQ_W | Sequence number of the recorded load |
| lq_count | output | CNT_W | Number of queued loads |
| lq_full | output | 1 | Occupancy is DEPTH-1 |
| head_idx | output | IDX_W | Slot of the oldest load |

## Verification
The sharpest overlap is allocation in the same cycle as a commit that frees the head while the queue is full. The allocation must still be refused, because fullness is judged on the starting count, while the head advances. A second overlap is two refusals by the cache in one cycle, where the higher lane holds the older load, possibly together with a clear. The bench provokes both cases directly and then repeats them at random. Every cycle it compares the queue state, the per-lane verdicts and the blocked record against a queue-based model that applies the commit, then the squash, then the allocation, and chooses the oldest refused sequence number.

// File: rtl/lqic_pkg.sv
// Package: shared verdict type for the load queue issue controller.
// Assumes nothing beyond standard SystemVerilog enum support.
package lqic_pkg;

    // Per-lane outcome of the issue decision in one cycle
    typedef enum logic [1:0] {
        GATE_IDLE         = 2'd0,
        GATE_SEND         = 2'd1,
        GATE_UNCACHE_HOLD = 2'd2,
        GATE_PORT_BUSY    = 2'd3
    } gate_e;

endpackage

// File: rtl/lqic_ring.sv
// Module: circular load queue holding sequence numbers in program order.
// Frees an older-than prefix on commit and a younger-than suffix on squash.
// Assumes DEPTH is a power of two and sequence numbers rise monotonically
// without wrapping while loads are in flight. One slot is always left free.
module lqic_ring #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_valid,
    input  logic [SEQ_W-1:0]             alloc_seq,
    input  logic                         commit_valid,
    input  logic [SEQ_W-1:0]             commit_seq,
    input  logic                         squash_valid,
    input  logic [SEQ_W-1:0]             squash_seq,
    output logic                         alloc_ready,
    output logic [IDX_W-1:0]             alloc_idx,
    output logic [IDX_W-1:0]             head_idx,
    output logic [CNT_W-1:0]             count,
    output logic                         full,
    output logic [DEPTH-1:0][SEQ_W-1:0]  seq_table
);

    logic [DEPTH-1:0][SEQ_W-1:0] seq_q;
    logic [IDX_W-1:0]            head_q;
    logic [CNT_W-1:0]            cnt_q;
    logic [DEPTH-1:0][IDX_W-1:0] slot_at;
    logic [CNT_W-1:0]            n_retire;
    logic [CNT_W-1:0]            n_drop;
    logic [CNT_W:0]              n_removed;
    logic [CNT_W-1:0]            cnt_kept;
    logic                        alloc_fire;

    // Slot address of the i-th oldest entry
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign slot_at[i] = head_q + IDX_W'(i);
    end

    // Count entries freed by commit (from head) and by squash (from tail)
    always_comb begin
        n_retire = '0;
        n_drop   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < cnt_q) begin
                if (commit_valid && (seq_q[slot_at[i]] < commit_seq))
                    n_retire = n_retire + CNT_W'(1);
                if (squash_valid && (seq_q[slot_at[i]] > squash_seq))
                    n_drop = n_drop + CNT_W'(1);
            end
        end
    end

    // Occupancy that survives this cycle's removals
    always_comb begin
        n_removed = {1'b0, n_retire} + {1'b0, n_drop};
        if (n_removed >= {1'b0, cnt_q})
            cnt_kept = '0;
        else
            cnt_kept = cnt_q - n_removed[CNT_W-1:0];
    end

    // Full and allocation acceptance use the start-of-cycle occupancy
    assign full        = (cnt_q == CNT_W'(DEPTH - 1));
    assign alloc_ready = !full && !squash_valid;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_idx   = head_q + cnt_q[IDX_W-1:0];
    assign head_idx    = head_q;
    assign count       = cnt_q;
    assign seq_table   = seq_q;

    // Update storage, head pointer and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= '0;
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (alloc_fire)
                seq_q[alloc_idx] <= alloc_seq;
            head_q <= head_q + n_retire[IDX_W-1:0];
            cnt_q  <= cnt_kept + CNT_W'(alloc_fire);
        end
    end

endmodule

// File: rtl/lqic_issue_gate.sv
// Module: per-cycle issue decision for all execute lanes.
// Applies the uncacheable head-and-commit rule, then grants cache ports in
// ascending lane order up to CACHE_PORTS. Purely combinational: the port
// count restarts from zero every cycle. Assumes each valid lane names an
// occupied slot.
module lqic_issue_gate
    import lqic_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int LANES       = 3,
    parameter int CACHE_PORTS = 2,
    parameter int SEQ_W       = 16,
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 3
) (
    input  logic [LANES-1:0]              exec_valid,
    input  logic [LANES-1:0][IDX_W-1:0]   exec_idx,
    input  logic [LANES-1:0][ADDR_W-1:0]  exec_addr,
    input  logic [LANES-1:0]              exec_uncache,
    input  logic [LANES-1:0]              exec_at_commit,
    input  logic [IDX_W-1:0]              head_idx,
    input  logic [DEPTH-1:0][SEQ_W-1:0]   seq_table,
    output logic [LANES-1:0]              req_valid,
    output logic [LANES-1:0][ADDR_W-1:0]  req_addr,
    output logic [LANES-1:0][SEQ_W-1:0]   req_seq,
    output logic [LANES-1:0]              resched,
    output logic [LANES-1:0]              fault
);

    localparam int PU_W = $clog2(LANES + CACHE_PORTS + 1);

    gate_e           verdict [LANES];
    logic [PU_W-1:0] ports_used;

    // Judge lanes in order, counting ports handed out in this cycle
    always_comb begin
        ports_used = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!exec_valid[l])
                verdict[l] = GATE_IDLE;
            else if (exec_uncache[l] &&
                     !((exec_idx[l] == head_idx) && exec_at_commit[l]))
                verdict[l] = GATE_UNCACHE_HOLD;
            else if (ports_used >= PU_W'(CACHE_PORTS))
                verdict[l] = GATE_PORT_BUSY;
            else begin
                verdict[l] = GATE_SEND;
                ports_used = ports_used + PU_W'(1);
            end
        end
    end

    // Map each lane's verdict onto its request and status outputs
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign req_valid[l] = (verdict[l] == GATE_SEND);
        assign resched[l]   = (verdict[l] == GATE_UNCACHE_HOLD) ||
                              (verdict[l] == GATE_PORT_BUSY);
        assign fault[l]     = (verdict[l] == GATE_UNCACHE_HOLD);
        assign req_addr[l]  = exec_addr[l];
        assign req_seq[l]   = seq_table[exec_idx[l]];
    end

endmodule

// File: rtl/lqic_block_rec.sv
// Module: record of the oldest load whose cache request was refused.
// A refusal replaces the record when none is held, when a clear arrives in
// the same cycle, or when the refused load is older than the one held.
// Assumes sequence numbers do not wrap while a record is held.
module lqic_block_rec #(
    parameter int LANES = 3,
    parameter int SEQ_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            req_valid,
    input  logic [LANES-1:0]            req_ready,
    input  logic [LANES-1:0][SEQ_W-1:0] req_seq,
    input  logic                        clr,
    input  logic                        handled_set,
    output logic                        blocked,
    output logic                        handled,
    output logic [SEQ_W-1:0]            bseq
);

    logic             blocked_q;
    logic             handled_q;
    logic [SEQ_W-1:0] bseq_q;
    logic             any_refused;
    logic [SEQ_W-1:0] oldest_seq;
    logic             take;

    // Find the oldest refused request in this cycle
    always_comb begin
        any_refused = 1'b0;
        oldest_seq  = '1;
        for (int l = 0; l < LANES; l++) begin
            if (req_valid[l] && !req_ready[l]) begin
                any_refused = 1'b1;
                if (req_seq[l] < oldest_seq)
                    oldest_seq = req_seq[l];
            end
        end
    end

    // Decide whether this cycle's refusal replaces the record
    assign take = any_refused && (!blocked_q || clr || (oldest_seq < bseq_q));

    // Hold the record, the blocked flag and the handled flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked_q <= 1'b0;
            handled_q <= 1'b0;
            bseq_q    <= '0;
        end else if (take) begin
            blocked_q <= 1'b1;
            handled_q <= 1'b0;
            bseq_q    <= oldest_seq;
        end else begin
            if (clr)
                blocked_q <= 1'b0;
            if (handled_set)
                handled_q <= 1'b1;
        end
    end

    assign blocked = blocked_q;
    assign handled = handled_q;
    assign bseq    = bseq_q;

endmodule

// File: rtl/lq_issue_ctrl.sv
// Module: top of the load queue issue controller.
// Joins the circular queue, the per-lane issue gate and the blocked-load
// record. Assumes DEPTH is a power of two, at least 2.
module lq_issue_ctrl #(
    parameter int DEPTH       = 8,
    parameter int LANES       = 3,
    parameter int CACHE_PORTS = 2,
    parameter int SEQ_W       = 16,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = $clog2(DEPTH),
    localparam int CNT_W      = $clog2(DEPTH) + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_valid,
    input  logic [SEQ_W-1:0]            alloc_seq,
    output logic                        alloc_ready,
    output logic [IDX_W-1:0]            alloc_idx,
    input  logic                        commit_valid,
    input  logic [SEQ_W-1:0]            commit_seq,
    input  logic                        squash_valid,
    input  logic [SEQ_W-1:0]            squash_seq,
    input  logic [LANES-1:0]            exec_valid,
    input  logic [LANES-1:0][IDX_W-1:0] exec_idx,
    input  logic [LANES-1:0][ADDR_W-1:0] exec_addr,
    input  logic [LANES-1:0]            exec_uncache,
    input  logic [LANES-1:0]            exec_at_commit,
    output logic [LANES-1:0]            cache_req_valid,
    output logic [LANES-1:0][ADDR_W-1:0] cache_req_addr,
    output logic [LANES-1:0][SEQ_W-1:0] cache_req_seq,
    input  logic [LANES-1:0]            cache_ready,
    output logic [LANES-1:0]            resched,
    output logic [LANES-1:0]            fault,
    input  logic                        blk_clear,
    input  logic                        blk_handled_set,
    output logic                        load_blocked,
    output logic                        blk_handled,
    output logic [SEQ_W-1:0]            blk_seq,
    output logic [CNT_W-1:0]            lq_count,
    output logic                        lq_full,
    output logic [IDX_W-1:0]            head_idx
);

    logic [DEPTH-1:0][SEQ_W-1:0] seq_table;

    // Queue storage and pointer management
    lqic_ring #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_valid  (alloc_valid),
        .alloc_seq    (alloc_seq),
        .commit_valid (commit_valid),
        .commit_seq   (commit_seq),
        .squash_valid (squash_valid),
        .squash_seq   (squash_seq),
        .alloc_ready  (alloc_ready),
        .alloc_idx    (alloc_idx),
        .head_idx     (head_idx),
        .count        (lq_count),
        .full         (lq_full),
        .seq_table    (seq_table)
    );

    // Per-lane issue decision
    lqic_issue_gate #(
        .DEPTH(DEPTH), .LANES(LANES), .CACHE_PORTS(CACHE_PORTS),
        .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_gate (
        .exec_valid     (exec_valid),
        .exec_idx       (exec_idx),
        .exec_addr      (exec_addr),
        .exec_uncache   (exec_uncache),
        .exec_at_commit (exec_at_commit),
        .head_idx       (head_idx),
        .seq_table      (seq_table),
        .req_valid      (cache_req_valid),
        .req_addr       (cache_req_addr),
        .req_seq        (cache_req_seq),
        .resched        (resched),
        .fault          (fault)
    );

    // Oldest cache-refused load record
    lqic_block_rec #(
        .LANES(LANES), .SEQ_W(SEQ_W)
    ) u_blk (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (cache_req_valid),
        .req_ready   (cache_ready),
        .req_seq     (cache_req_seq),
        .clr         (blk_clear),
        .handled_set (blk_handled_set),
        .blocked     (load_blocked),
        .handled     (blk_handled),
        .bseq        (blk_seq)
    );

endmodule

// File: rtl/lq_issue_ctrl_chk.sv
// Module: property checker for lq_issue_ctrl, attached through bind.
// Observes the top-level ports only.
module lq_issue_ctrl_chk #(
    parameter int DEPTH       = 8,
    parameter int LANES       = 3,
    parameter int CACHE_PORTS = 2,
    parameter int SEQ_W       = 16,
    parameter int IDX_W       = 3,
    parameter int CNT_W       = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        alloc_valid,
    input logic                        alloc_ready,
    input logic                        commit_valid,
    input logic [CNT_W-1:0]            lq_count,
    input logic [IDX_W-1:0]            head_idx,
    input logic [LANES-1:0][IDX_W-1:0] exec_idx,
    input logic [LANES-1:0]            exec_uncache,
    input logic [LANES-1:0]            exec_at_commit,
    input logic [LANES-1:0]            cache_req_valid,
    input logic [LANES-1:0]            cache_ready,
    input logic [LANES-1:0]            resched,
    input logic [LANES-1:0]            fault,
    input logic                        blk_clear,
    input logic                        load_blocked,
    input logic                        blk_handled,
    input logic [SEQ_W-1:0]            blk_seq
);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        lq_count <= CNT_W'(DEPTH - 1)); // R3

    AST_ALLOC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && !commit_valid)
        |=> (lq_count == $past(lq_count) + CNT_W'(1))); // R2

    AST_PORT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cache_req_valid) <= CACHE_PORTS); // R8

    AST_REFUSE_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cache_req_valid & ~cache_ready)) |=> load_blocked); // R9

    AST_FRESH_UNHANDLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(cache_req_valid & ~cache_ready)) && !load_blocked) |=> !blk_handled); // R9

    AST_KEEP_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        (load_blocked && !blk_clear)
        |=> (load_blocked && (blk_seq <= $past(blk_seq)))); // R10

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        AST_UNCACHE_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
            (cache_req_valid[l] && exec_uncache[l])
            |-> ((exec_idx[l] == head_idx) && exec_at_commit[l])); // R6

        AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            fault[l] |-> (resched[l] && !cache_req_valid[l])); // R6
    end

endmodule

bind lq_issue_ctrl lq_issue_ctrl_chk #(
    .DEPTH(DEPTH), .LANES(LANES), .CACHE_PORTS(CACHE_PORTS),
    .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_valid    (alloc_valid),
    .alloc_ready    (alloc_ready),
    .commit_valid   (commit_valid),
    .lq_count       (lq_count),
    .head_idx       (head_idx),
    .exec_idx       (exec_idx),
    .exec_uncache   (exec_uncache),
    .exec_at_commit (exec_at_commit),
    .cache_req_valid(cache_req_valid),
    .cache_ready    (cache_ready),
    .resched        (resched),
    .fault          (fault),
    .blk_clear      (blk_clear),
    .load_blocked   (load_blocked),
    .blk_handled    (blk_handled),
    .blk_seq        (blk_seq)
);

// File: tb/lq_issue_ctrl_tb.sv
// Bench: directed corner cases, then random traffic. A queue-based model is
// compared against the DUT on every clock.
module lq_issue_ctrl_tb;

    localparam int D  = 8;
    localparam int L  = 3;
    localparam int CP = 2;
    localparam int SW = 16;
    localparam int AW = 32;
    localparam int IW = $clog2(D);
    localparam int CW = $clog2(D) + 1;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  alloc_valid;
    logic [SW-1:0]         alloc_seq;
    logic                  alloc_ready;
    logic [IW-1:0]         alloc_idx;
    logic                  commit_valid;
    logic [SW-1:0]         commit_seq;
    logic                  squash_valid;
    logic [SW-1:0]         squash_seq;
    logic [L-1:0]          exec_valid;
    logic [L-1:0][IW-1:0]  exec_idx;
    logic [L-1:0][AW-1:0]  exec_addr;
    logic [L-1:0]          exec_uncache;
    logic [L-1:0]          exec_at_commit;
    logic [L-1:0]          cache_req_valid;
    logic [L-1:0][AW-1:0]  cache_req_addr;
    logic [L-1:0][SW-1:0]  cache_req_seq;
    logic [L-1:0]          cache_ready;
    logic [L-1:0]          resched;
    logic [L-1:0]          fault;
    logic                  blk_clear;
    logic                  blk_handled_set;
    logic                  load_blocked;
    logic                  blk_handled;
    logic [SW-1:0]         blk_seq;
    logic [CW-1:0]         lq_count;
    logic                  lq_full;
    logic [IW-1:0]         head_idx;

    lq_issue_ctrl #(
        .DEPTH(D), .LANES(L), .CACHE_PORTS(CP), .SEQ_W(SW), .ADDR_W(AW)
    ) u_dut (.*);

    always #5 clk = ~clk;

    // Reference state
    int q[$];
    int hd;
    bit mblk, mhnd;
    int mbseq;
    int next_seq;
    int lane_pos [L];
    bit exp_req  [L];
    int n_cmp, n_bad;
    bit done;

    task automatic chk(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_seq = '0;
        commit_valid = 0; commit_seq = '0;
        squash_valid = 0; squash_seq = '0;
        exec_valid = '0; exec_idx = '0; exec_addr = '0;
        exec_uncache = '0; exec_at_commit = '0; cache_ready = '1;
        blk_clear = 0; blk_handled_set = 0;
    endtask

    task automatic set_lane(int l, int pos, bit unc, bit atc, bit rdy);
        exec_valid[l]     = 1'b1;
        lane_pos[l]       = pos;
        exec_idx[l]       = IW'((hd + pos) % D);
        exec_addr[l]      = AW'($urandom);
        exec_uncache[l]   = unc;
        exec_at_commit[l] = atc;
        cache_ready[l]    = rdy;
    endtask

    // Compare every output against the model for the current inputs
    task automatic check_outputs();
        int used;
        int sz;
        sz = q.size();
        chk("R2 R4 R5 count", lq_count, sz);
        chk("R3 full", lq_full, sz == D - 1);
        chk("R3 alloc_ready", alloc_ready, (sz < D - 1) && !squash_valid);
        chk("R2 alloc_idx", alloc_idx, (hd + sz) % D);
        chk("R4 head", head_idx, hd);
        chk("R9 blocked", load_blocked, mblk);
        chk("R11 handled", blk_handled, mhnd);
        if (mblk) chk("R10 blk_seq", blk_seq, mbseq);
        used = 0;
        for (int l = 0; l < L; l++) begin
            bit er, es, ef;
            string tg;
            er = 0; es = 0; ef = 0; tg = "R7";
            if (exec_valid[l]) begin
                if (exec_uncache[l] && !((int'(exec_idx[l]) == hd) && exec_at_commit[l])) begin
                    es = 1; ef = 1; tg = "R6";
                end else if (used >= CP) begin
                    es = 1; tg = "R8";
                end else begin
                    er = 1; used++;
                end
            end
            exp_req[l] = er;
            chk({tg, " req"}, cache_req_valid[l], er);
            chk({tg, " resched"}, resched[l], es);
            chk({tg, " fault"}, fault[l], ef);
            if (er) begin
                chk("R7 addr", cache_req_addr[l], exec_addr[l]);
                chk("R7 seq", cache_req_seq[l], q[lane_pos[l]]);
            end
        end
    endtask

    // Advance the model across one clock edge
    task automatic update_model();
        int sz0;
        bit af, any;
        int mn;
        sz0 = q.size();
        af = alloc_valid && (sz0 < D - 1) && !squash_valid;
        any = 0; mn = 0;
        for (int l = 0; l < L; l++) begin
            if (exp_req[l] && !cache_ready[l]) begin
                if (!any || q[lane_pos[l]] < mn) mn = q[lane_pos[l]];
                any = 1;
            end
        end
        if (commit_valid)
            while (q.size() > 0 && q[0] < int'(commit_seq)) begin
                void'(q.pop_front());
                hd = (hd + 1) % D;
            end
        if (squash_valid)
            while (q.size() > 0 && q[q.size()-1] > int'(squash_seq))
                void'(q.pop_back());
        if (af) begin
            q.push_back(int'(alloc_seq));
            next_seq += 1 + int'($urandom % 3);
        end
        if (any && (!mblk || blk_clear || mn < mbseq)) begin
            mblk = 1; mhnd = 0; mbseq = mn;
        end else begin
            if (blk_clear) mblk = 0;
            if (blk_handled_set) mhnd = 1;
        end
    endtask

    task automatic cycle();
        #1;
        check_outputs();
        @(posedge clk);
        update_model();
        @(negedge clk);
        idle();
    endtask

    task automatic drive_random();
        int sz;
        sz = q.size();
        alloc_valid = ($urandom % 3) != 0;
        alloc_seq   = SW'(next_seq);
        commit_valid = ($urandom % 4) == 0;
        commit_seq   = (sz > 0) ? SW'(q[$urandom % sz] + 1) : SW'(next_seq);
        squash_valid = ($urandom % 10) == 0;
        squash_seq   = (sz > 0) ? SW'(q[$urandom % sz]) : '0;
        for (int l = 0; l < L; l++) begin
            if (sz > 0 && ($urandom % 3) != 0)
                set_lane(l, (($urandom % 3) == 0) ? 0 : int'($urandom % sz),
                         ($urandom % 4) == 0, $urandom % 2, ($urandom % 4) != 0);
        end
        blk_clear       = ($urandom % 12) == 0;
        blk_handled_set = ($urandom % 6) == 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        n_cmp = 0; n_bad = 0; done = 0;
        hd = 0; mblk = 0; mhnd = 0; mbseq = 0; next_seq = 10;
        for (int l = 0; l < L; l++) begin lane_pos[l] = 0; exp_req[l] = 0; end
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 count", lq_count, 0);
        chk("R1 head", head_idx, 0);
        chk("R1 full", lq_full, 0);
        chk("R1 alloc_ready", alloc_ready, 1);
        chk("R1 blocked", load_blocked, 0);

        // R2/R3: fill past capacity, then alloc with commit while full
        for (int i = 0; i < D; i++) begin
            alloc_valid = 1; alloc_seq = SW'(next_seq);
            cycle();
        end
        alloc_valid = 1; alloc_seq = SW'(next_seq);
        commit_valid = 1; commit_seq = SW'(q[0] + 1);
        cycle();

        // R6/R7: uncacheable gating at head and commit
        set_lane(0, 1, 1, 1, 1);
        set_lane(1, 0, 1, 0, 1);
        set_lane(2, 0, 1, 1, 1);
        cycle();

        // R8: three cacheable lanes, two ports
        set_lane(0, 2, 0, 0, 1);
        set_lane(1, 3, 0, 0, 1);
        set_lane(2, 4, 0, 0, 1);
        cycle();

        // R9: two refusals in one cycle, higher lane holds the older load
        set_lane(0, 3, 0, 0, 0);
        set_lane(1, 1, 0, 0, 0);
        cycle();
        // R10: older refusal replaces, younger does not
        set_lane(0, 0, 0, 0, 0);
        cycle();
        set_lane(0, 4, 0, 0, 0);
        cycle();
        // R11: handled, clear, then clear with a refusal in the same cycle
        blk_handled_set = 1;
        cycle();
        blk_clear = 1;
        cycle();
        blk_clear = 1; blk_handled_set = 1;
        set_lane(0, 5, 0, 0, 0);
        cycle();

        // R5: squash to the middle, with an allocation that must be refused
        squash_valid = 1; squash_seq = SW'(q[2]);
        alloc_valid = 1; alloc_seq = SW'(next_seq);
        cycle();
        // R4: commit every remaining load
        commit_valid = 1; commit_seq = SW'(next_seq);
        cycle();

        for (int n = 0; n < 4000; n++) begin
            drive_random();
            cycle();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule